// File: doc/BRIEF.md
# Two-Dimensional Indexed Address Generator

This block walks one block transfer and emits, for every element, a pair of addresses: one to read from and one to write to. A transfer is described by two start addresses, the number of elements per frame, the number of frames less one, a signed element stride, a signed frame stride, an element size and an addressing mode for each side. The read side and the write side step independently, so one transfer can gather from a strided source, scatter into a buffer, interleave or de-interleave, or hold one side on a fixed peripheral register.

Pairs leave on a valid/ready interface, and the final pair carries a last flag. A trigger on `start` while idle captures the whole setup and begins. In frame-synchronised operation the generator stops after each frame that is not the final one and waits for another trigger. Otherwise the whole block runs from one trigger. Each side can also run in an array mode. There, elements inside an array are contiguous, and each new array begins one frame stride after the start of the previous array.

Top module: `dma_addr_seq2d`

## Requirements
- R1: After reset, `out_valid`, `out_last` and `busy` are low.
- R2: A `start` pulse while idle captures the setup, raises `busy` and presents the two start addresses as the first pair on the next cycle. Without `start` the block stays idle. `elem_count` gives the elements per frame (at least 1) and `frame_count_m1` gives the number of frames less one.
- R3: Mode code 00 on a side keeps that side's address at its start value for every pair.
- R4: Mode code 01 adds the element size to the address after every pair, and code 10 subtracts it. This also holds across frame boundaries. Size code 00 is 1 byte, 01 is 2 bytes and 10 is 4 bytes.
- R5: Mode code 11 with the array flag low adds the sign-extended element stride between elements of a frame. From the last element of a frame to the first of the next, it adds the sign-extended frame stride instead. All address arithmetic wraps modulo 2^32.
- R6: Mode code 11 with the array flag high steps by the element size inside an array. Each array starts at the previous array's start plus the sign-extended frame stride.
- R7: While `out_valid` is high and `out_ready` is low, the pair and `out_valid` hold unchanged.
- R8: `out_last` is high together with the final pair only. After that pair is accepted, `out_valid` and `busy` are low on the next cycle.
- R9: With `frame_sync` high, after each frame that is not the final one, `out_valid` drops while `busy` stays high. The next `start` resumes with the first pair of the next frame.
- R10: With `frame_sync` low and `out_ready` held high, a new pair is offered on every cycle from the first pair to the last.
- R11: A `start` pulse while pairs are being offered has no effect on the sequence.
- R12: Exactly `elem_count * (frame_count_m1 + 1)` pairs are offered per transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Trigger: begins a transfer when idle, releases the next frame when waiting |
| src_base | input | 32 | Read-side start address |
| dst_base | input | 32 | Write-side start address |
| src_mode | input | 2 | Read-side mode: 00 fixed, 01 up, 10 down, 11 strided |
| dst_mode | input | 2 | Write-side mode, same coding |
| src_2d | input | 1 | Read-side array mode |
| dst_2d | input | 1 | Write-side array mode |
| elem_size | input | 2 | 00 byte, 01 half-word, 10 word |
| elem_count | input | 16 | Elements per frame |
| frame_count_m1 | input | 16 | Frames less one |
| elem_step | input | 16 | Signed stride between elements |
| frame_step | input | 16 | Signed stride between frames or arrays |
| frame_sync | input | 1 | One frame per trigger when high |
| out_valid | output | 1 | Pair offered |
| out_ready | input | 1 | Pair accepted when high with `out_valid` |
| src_addr | output | 32 | Read address of the current element |
| dst_addr | output | 32 | Write address of the current element |
| out_last | output | 1 | Current pair is the final one |
| busy | output | 1 | A transfer is in progress |

## Verification
The assertions read mode and size straight from the input pins. They therefore rely on the setup inputs staying constant while `busy` is high, on `elem_count` never being zero, and on size code 11 never being used. The bench changes the setup only between transfers, after `busy` has fallen, and uses only counts of one or more and the three defined sizes. Stall checks rely on `out_ready` being driven between clock edges, and the bench drives it on the falling edge.

// File: rtl/dma_addr_seq2d.sv
module dma_addr_seq2d #(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int IW = 16
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] src_base,
  input  logic [AW-1:0] dst_base,
  input  logic [1:0]    src_mode,
  input  logic [1:0]    dst_mode,
  input  logic          src_2d,
  input  logic          dst_2d,
  input  logic [1:0]    elem_size,
  input  logic [CW-1:0] elem_count,
  input  logic [CW-1:0] frame_count_m1,
  input  logic [IW-1:0] elem_step,
  input  logic [IW-1:0] frame_step,
  input  logic          frame_sync,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [AW-1:0] src_addr,
  output logic [AW-1:0] dst_addr,
  output logic          out_last,
  output logic          busy
);
  localparam int XW = AW - IW;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_HOLD} st_t;
  st_t state;

  logic [1:0]    r_smode, r_dmode, r_size;
  logic          r_s2d, r_d2d, r_fs;
  logic [CW-1:0] r_ecount, ecnt, fcnt;
  logic [IW-1:0] r_estep, r_fstep;
  logic [AW-1:0] s_cur, d_cur, s_row, d_row;

  logic [AW-1:0] sz, e_ext, f_ext, s_nxt, d_nxt;
  logic          frame_end, last_pair, fire;

  function automatic logic [AW-1:0] advance(
    input logic [AW-1:0] cur,
    input logic [AW-1:0] row,
    input logic [1:0]    mode,
    input logic          two_d,
    input logic          fend,
    input logic [AW-1:0] sz_i,
    input logic [AW-1:0] e_i,
    input logic [AW-1:0] f_i
  );
    logic [AW-1:0] r;
    case (mode)
      2'b00:   r = cur;
      2'b01:   r = cur + sz_i;
      2'b10:   r = cur - sz_i;
      default: begin
        if (two_d) r = fend ? row + f_i : cur + sz_i;
        else       r = cur + (fend ? f_i : e_i);
      end
    endcase
    return r;
  endfunction

  assign sz        = (r_size == 2'd0) ? AW'(1) : (r_size == 2'd1) ? AW'(2) : AW'(4);
  assign e_ext     = {{XW{r_estep[IW-1]}}, r_estep};
  assign f_ext     = {{XW{r_fstep[IW-1]}}, r_fstep};
  assign frame_end = (ecnt == CW'(1));
  assign last_pair = frame_end && (fcnt == '0);
  assign fire      = out_valid && out_ready;
  assign s_nxt     = advance(s_cur, s_row, r_smode, r_s2d, frame_end, sz, e_ext, f_ext);
  assign d_nxt     = advance(d_cur, d_row, r_dmode, r_d2d, frame_end, sz, e_ext, f_ext);

  assign out_valid = (state == S_RUN);
  assign out_last  = out_valid && last_pair;
  assign busy      = (state != S_IDLE);
  assign src_addr  = s_cur;
  assign dst_addr  = d_cur;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      r_smode  <= '0;
      r_dmode  <= '0;
      r_size   <= '0;
      r_s2d    <= 1'b0;
      r_d2d    <= 1'b0;
      r_fs     <= 1'b0;
      r_ecount <= '0;
      r_estep  <= '0;
      r_fstep  <= '0;
      ecnt     <= '0;
      fcnt     <= '0;
      s_cur    <= '0;
      d_cur    <= '0;
      s_row    <= '0;
      d_row    <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (start) begin
            r_smode  <= src_mode;
            r_dmode  <= dst_mode;
            r_size   <= elem_size;
            r_s2d    <= src_2d;
            r_d2d    <= dst_2d;
            r_fs     <= frame_sync;
            r_ecount <= elem_count;
            r_estep  <= elem_step;
            r_fstep  <= frame_step;
            ecnt     <= elem_count;
            fcnt     <= frame_count_m1;
            s_cur    <= src_base;
            d_cur    <= dst_base;
            s_row    <= src_base;
            d_row    <= dst_base;
            state    <= S_RUN;
          end
        end
        S_RUN: begin
          if (fire) begin
            if (last_pair) begin
              state <= S_IDLE;
            end else begin
              s_cur <= s_nxt;
              d_cur <= d_nxt;
              if (frame_end) begin
                s_row <= s_nxt;
                d_row <= d_nxt;
                ecnt  <= r_ecount;
                fcnt  <= fcnt - CW'(1);
                if (r_fs) state <= S_HOLD;
              end else begin
                ecnt <= ecnt - CW'(1);
              end
            end
          end
        end
        S_HOLD: begin
          if (start) state <= S_RUN;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_addr_seq2d_chk.sv
module dma_addr_seq2d_chk #(
  parameter int AW = 32
)(
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [1:0]    src_mode,
  input logic [1:0]    dst_mode,
  input logic [1:0]    elem_size,
  input logic          out_valid,
  input logic          out_ready,
  input logic          out_last,
  input logic [AW-1:0] src_addr,
  input logic [AW-1:0] dst_addr,
  input logic          busy
);
  logic [AW-1:0] esz;
  assign esz = (elem_size == 2'd0) ? AW'(1) : (elem_size == 2'd1) ? AW'(2) : AW'(4);

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(src_addr) && $stable(dst_addr)); // R7

  AST_LAST_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> !out_valid && !busy); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !start |=> !busy && !out_valid); // R2

  AST_SRC_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !out_last && src_mode == 2'b00 |=> src_addr == $past(src_addr)); // R3

  AST_DST_UP: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !out_last && dst_mode == 2'b01 |=> dst_addr == $past(dst_addr) + $past(esz)); // R4

  AST_DST_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !out_last && dst_mode == 2'b10 |=> dst_addr == $past(dst_addr) - $past(esz)); // R4
endmodule

bind dma_addr_seq2d dma_addr_seq2d_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .src_mode(src_mode), .dst_mode(dst_mode),
  .elem_size(elem_size), .out_valid(out_valid), .out_ready(out_ready), .out_last(out_last),
  .src_addr(src_addr), .dst_addr(dst_addr), .busy(busy)
);

// File: tb/dma_addr_seq2d_bench.sv
module dma_addr_seq2d_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] src_base = '0, dst_base = '0;
  logic [1:0]  src_mode = '0, dst_mode = '0, elem_size = '0;
  logic        src_2d = 1'b0, dst_2d = 1'b0, frame_sync = 1'b0, out_ready = 1'b0;
  logic [15:0] elem_count = 16'd1, frame_count_m1 = '0, elem_step = '0, frame_step = '0;
  logic        out_valid, out_last, busy;
  logic [31:0] src_addr, dst_addr;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  dma_addr_seq2d u_dma_addr_seq2d (
    .clk(clk), .rst_n(rst_n), .start(start), .src_base(src_base), .dst_base(dst_base),
    .src_mode(src_mode), .dst_mode(dst_mode), .src_2d(src_2d), .dst_2d(dst_2d),
    .elem_size(elem_size), .elem_count(elem_count), .frame_count_m1(frame_count_m1),
    .elem_step(elem_step), .frame_step(frame_step), .frame_sync(frame_sync),
    .out_valid(out_valid), .out_ready(out_ready), .src_addr(src_addr), .dst_addr(dst_addr),
    .out_last(out_last), .busy(busy)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_addr(input logic [31:0] base, input logic [1:0] mode,
      input bit two_d, input logic [1:0] szc, input int ecount, input int f, input int e,
      input int es, input int fst);
    int sz;
    int lin;
    sz  = (szc == 2'd0) ? 1 : (szc == 2'd1) ? 2 : 4;
    lin = f * ecount + e;
    case (mode)
      2'b00:   return base;
      2'b01:   return base + 32'(lin * sz);
      2'b10:   return base - 32'(lin * sz);
      default: begin
        if (two_d) return base + 32'(f * fst) + 32'(e * sz);
        else       return base + 32'(f * ((ecount - 1) * es + fst)) + 32'(e * es);
      end
    endcase
  endfunction

  task automatic run_xfer(input string tag, input logic [31:0] sb, input logic [31:0] db,
      input logic [1:0] sm, input logic [1:0] dm, input bit s2, input bit d2, input logic [1:0] szc,
      input int ecount, input int fcm1, input int es, input int fst, input bit sync,
      input int rpat, input bit poke);
    int total, idx, hold, cyc, f, e;
    bit poked;
    logic [31:0] es_v, fs_v;
    es_v = 32'(es);
    fs_v = 32'(fst);
    src_base = sb; dst_base = db; src_mode = sm; dst_mode = dm;
    src_2d = s2; dst_2d = d2; elem_size = szc;
    elem_count = 16'(ecount); frame_count_m1 = 16'(fcm1);
    elem_step = es_v[15:0]; frame_step = fs_v[15:0]; frame_sync = sync;
    total = ecount * (fcm1 + 1);
    idx = 0; hold = 0; cyc = 0; poked = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (idx < total) begin
      start = 1'b0;
      out_ready = (rpat == 0) ? 1'b1 : ((cyc % 3) != 1);
      if (poke && !poked && idx == 2) begin
        start = 1'b1;  // R11: ignored while offering pairs
        poked = 1'b1;
      end
      #1;
      if (out_valid) begin
        hold = 0;
        f = idx / ecount;
        e = idx % ecount;
        check(src_addr == exp_addr(sb, sm, s2, szc, ecount, f, e, es, fst),
              {tag, " R3/R4/R5/R6/R7/R11 src"}, src_addr,
              exp_addr(sb, sm, s2, szc, ecount, f, e, es, fst));
        check(dst_addr == exp_addr(db, dm, d2, szc, ecount, f, e, es, fst),
              {tag, " R2/R4/R5/R6/R7 dst"}, dst_addr,
              exp_addr(db, dm, d2, szc, ecount, f, e, es, fst));
        if (out_ready) begin
          check(out_last == (idx == total - 1), {tag, " R8 last flag"}, 32'(out_last), 32'(idx == total - 1));
          idx++;
        end
      end else if (sync && idx > 0 && (idx % ecount) == 0) begin
        hold++;
        if (hold == 1) check(busy == 1'b1, {tag, " R9 busy while waiting for frame trigger"}, 32'(busy), 32'd1);
        if (hold == 3) start = 1'b1;
      end else begin
        check(1'b0, {tag, " R10 unexpected gap"}, 32'(out_valid), 32'd1);
      end
      cyc++;
      @(negedge clk);
    end
    start = 1'b0;
    out_ready = 1'b0;
    #1;
    check(!out_valid && !busy, {tag, " R8 idle after final pair"}, {30'd0, out_valid, busy}, 32'd0);
    @(negedge clk);
    #1;
    check(!out_valid, {tag, " R12 no extra pair"}, 32'(out_valid), 32'd0);
    @(negedge clk);
  endtask

  task automatic test_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check(!out_valid && !out_last && !busy, "R1 reset state", {29'd0, out_valid, out_last, busy}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    repeat (2) @(negedge clk);
    #1;
    check(!busy && !out_valid, "R2 stays idle without start", {30'd0, busy, out_valid}, 32'd0);
    @(negedge clk);
  endtask

  task automatic test_gather;
    run_xfer("gather", 32'h1000_0000, 32'h2000_0000, 2'b11, 2'b01, 1'b0, 1'b0, 2'd2,
             4, 2, 8, -4, 1'b0, 0, 1'b0);
  endtask

  task automatic test_sync_fixed;
    run_xfer("sync", 32'h4000_0010, 32'h3000_0000, 2'b00, 2'b11, 1'b0, 1'b0, 2'd1,
             3, 2, 6, 2, 1'b1, 1, 1'b0);
  endtask

  task automatic test_array_down;
    run_xfer("array", 32'h5000_0000, 32'h6000_0100, 2'b11, 2'b10, 1'b1, 1'b0, 2'd0,
             5, 3, 100, 256, 1'b0, 1, 1'b1);
  endtask

  task automatic test_wrap;
    run_xfer("wrap", 32'hFFFF_FFF0, 32'h0000_0004, 2'b01, 2'b11, 1'b0, 1'b0, 2'd2,
             8, 0, -2, 0, 1'b0, 0, 1'b0);
    run_xfer("single", 32'h0000_0040, 32'h0000_0080, 2'b10, 2'b11, 1'b1, 1'b1, 2'd1,
             1, 0, 0, 0, 1'b1, 1, 1'b0);
  endtask

  initial begin
    test_reset();
    test_gather();
    test_sync_fixed();
    test_array_down();
    test_wrap();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule